// File: doc/BRIEF.md
# Segment Register Load Checker

This block decides what happens when a data or stack segment register is loaded from a selector taken off the stack. A request names the target register, the 16-bit selector, the current privilege level and whether the core runs in 64-bit mode. It also carries the byte limit of the descriptor table. Requests that can be settled from the selector alone are answered one cycle after they are accepted. These are forbidden targets, targets that 64-bit mode rejects, and null selectors. Every other request raises a one-cycle fetch request. The caller then returns the descriptor fields (present bit, code/data bit, type, privilege level) with a valid strobe, and the outcome follows one cycle later.

The outcome is a single-cycle result strobe. With it comes either a load enable together with the selector and the descriptor-cache contents, or exactly one fault line together with its error code. The caller writes the visible selector and the hidden cache from these outputs in that one cycle.

Top module: `segld_top`

## Requirements
- R1: Target codes are 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS and 5 = GS. Target CS, and the unused codes 6 and 7, raise the invalid-operation fault with error code 0 and no descriptor fetch, in either mode.
- R2: When `req_long` is 1, targets ES, SS and DS raise the invalid-operation fault with error code 0 and no fetch. FS and GS proceed normally.
- R3: A selector whose bits 15:2 are all zero is null. A null selector loaded into ES, DS, FS or GS is loaded with no fetch. `load_sel` is the selector, `load_cache_valid` is 0 and all descriptor outputs are 0.
- R4: A null selector loaded into SS raises the general protection fault with error code 0 and no fetch.
- R5: For SS with a non-null selector, a general protection fault is raised when RPL (selector bits 1:0) differs from CPL, DPL differs from CPL, or the segment is not a writable data segment. Descriptor encoding: `desc_s` = 1 marks code/data; within that, `desc_type[3]` = 1 is code, `desc_type[2]` is conforming (code), and `desc_type[1]` is readable (code) or writable (data).
- R6: For ES/DS/FS/GS with a non-null selector, a general protection fault is raised in two cases. The first is a segment that is neither data nor readable code. The second is a data or non-conforming code segment where both RPL and CPL are numerically greater than DPL.
- R7: A general protection fault is raised when the last byte of the descriptor, selector index × 8 + 7, is greater than `tbl_limit`. The comparison uses the limit present at acceptance.
- R8: When all protection checks pass and `desc_present` is 0, the result is the stack fault for SS and the not-present fault for the other targets.
- R9: When no fault applies to a fetched descriptor, `load_en` is 1 with `load_sel` set to the selector, `load_cache_valid` set to 1 and the descriptor fields copied. `load_en` is never 1 together with a fault.
- R10: Timing. A direct outcome appears one cycle after acceptance. Otherwise `fetch_req` pulses one cycle after acceptance and the outcome appears one cycle after `desc_valid`. `res_valid` lasts one cycle and nothing is reported while the descriptor is awaited.
- R11: `fault` is one-hot under `res_valid`, with bit 0 = general protection, 1 = not present, 2 = stack, 3 = invalid operation. Descriptor-based faults carry the selector with bits 1:0 cleared as error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_target | input | 3 | Target register code |
| req_sel | input | 16 | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| req_long | input | 1 | 64-bit mode |
| tbl_limit | input | 16 | Descriptor table byte limit |
| fetch_req | output | 1 | Descriptor fetch wanted (one-cycle pulse) |
| desc_valid | input | 1 | Descriptor fields valid |
| desc_present | input | 1 | Segment present bit |
| desc_s | input | 1 | Code/data (1) or system (0) |
| desc_type | input | 4 | Segment type field |
| desc_dpl | input | 2 | Descriptor privilege level |
| res_valid | output | 1 | Outcome strobe |
| load_en | output | 1 | Write selector and cache |
| load_sel | output | 16 | Selector to write |
| load_cache_valid | output | 1 | Cache entry usable (0 for null) |
| load_present | output | 1 | Cache present bit |
| load_s | output | 1 | Cache code/data bit |
| load_type | output | 4 | Cache type |
| load_dpl | output | 2 | Cache privilege level |
| fault | output | 4 | One-hot fault class |
| err_code | output | 16 | Fault error code |

## Verification
The properties assume that `desc_valid` is raised only while a fetch is outstanding and that `req_valid` stays low from acceptance until the outcome. They also assume the descriptor fields are stable while `desc_valid` is high. The stimulus issues one request at a time. It raises `desc_valid` only after observing `fetch_req`, and only after zero to two idle cycles, and drops it right after the outcome. The sweeps cover every target, privilege combination, type code, present state and both sides of the limit boundary.

// File: rtl/segld_pkg.sv
package segld_pkg;

   localparam logic [2:0] TGT_ES = 3'd0;
   localparam logic [2:0] TGT_CS = 3'd1;
   localparam logic [2:0] TGT_SS = 3'd2;
   localparam logic [2:0] TGT_DS = 3'd3;
   localparam logic [2:0] TGT_FS = 3'd4;
   localparam logic [2:0] TGT_GS = 3'd5;

   localparam int FLT_GP = 0;
   localparam int FLT_NP = 1;
   localparam int FLT_SS = 2;
   localparam int FLT_UD = 3;
   localparam int FLT_W  = 4;

   typedef struct packed {
      logic       present;
      logic       s;
      logic [3:0] typ;
      logic [1:0] dpl;
   } seg_desc_t;

   typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seg_state_e;

endpackage

// File: rtl/segld_sel_decode.sv
module segld_sel_decode
   import segld_pkg::*;
#(
   parameter int SEL_W = 16,
   parameter int LIM_W = 16
) (
   input  logic [2:0]       target,
   input  logic [SEL_W-1:0] sel,
   input  logic             long_mode,
   input  logic [LIM_W-1:0] limit,
   output logic             is_null,
   output logic             is_ss,
   output logic             reject_ud,
   output logic             beyond
);
   localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

   generate
      if (SEL_W < 4) begin : g_bad_sel
         $error("segld_sel_decode: SEL_W must be at least 4");
      end
      if (LIM_W < 3) begin : g_bad_lim
         $error("segld_sel_decode: LIM_W must be at least 3");
      end
   endgenerate

   logic [CMP_W-1:0] end_byte;
   logic [CMP_W-1:0] lim_ext;

   generate
      if (CMP_W == SEL_W) begin : g_sel_wide
         assign end_byte = {sel[SEL_W-1:3], 3'b111};
         assign lim_ext  = CMP_W'(limit);
      end else begin : g_lim_wide
         assign end_byte = CMP_W'({sel[SEL_W-1:3], 3'b111});
         assign lim_ext  = limit;
      end
   endgenerate

   assign beyond  = end_byte > lim_ext;
   assign is_null = (sel[SEL_W-1:2] == '0);
   assign is_ss   = (target == TGT_SS);

   always_comb begin
      case (target)
         TGT_ES, TGT_SS, TGT_DS: reject_ud = long_mode;
         TGT_FS, TGT_GS:         reject_ud = 1'b0;
         default:                reject_ud = 1'b1;
      endcase
   end

endmodule

// File: rtl/segld_rules.sv
module segld_rules
   import segld_pkg::*;
(
   input  logic      is_ss,
   input  logic      beyond,
   input  logic [1:0] rpl,
   input  logic [1:0] cpl,
   input  seg_desc_t desc,
   output logic      prot_fail,
   output logic      absent
);
   logic is_data;
   logic is_code;
   logic ss_bad;
   logic ds_bad;
   logic priv_low;

   assign is_data  = desc.s & ~desc.typ[3];
   assign is_code  = desc.s &  desc.typ[3];
   assign priv_low = (rpl > desc.dpl) & (cpl > desc.dpl);

   assign ss_bad = beyond | (rpl != cpl) | (desc.dpl != cpl)
                 | ~(is_data & desc.typ[1]);

   assign ds_bad = beyond | ~(is_data | (is_code & desc.typ[1]))
                 | ((is_data | (is_code & ~desc.typ[2])) & priv_low);

   assign prot_fail = is_ss ? ss_bad : ds_bad;
   assign absent    = ~desc.present;

endmodule

// File: rtl/segld_outreg.sv
module segld_outreg
   import segld_pkg::*;
#(
   parameter int SEL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             do_load,
   input  logic             cache_valid_in,
   input  seg_desc_t        desc_in,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [FLT_W-1:0] fault_in,
   input  logic [SEL_W-1:0] err_in,
   output logic             res_valid,
   output logic             load_en,
   output logic             load_cache_valid,
   output seg_desc_t        load_desc,
   output logic [SEL_W-1:0] load_sel,
   output logic [FLT_W-1:0] fault,
   output logic [SEL_W-1:0] err_code
);
   logic take_load;
   logic take_fault;

   assign take_load  = strobe & do_load;
   assign take_fault = strobe & (|fault_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid        <= 1'b0;
         load_en          <= 1'b0;
         load_cache_valid <= 1'b0;
         load_desc        <= '0;
         load_sel         <= '0;
         fault            <= '0;
         err_code         <= '0;
      end else begin
         res_valid        <= strobe;
         load_en          <= take_load;
         load_cache_valid <= take_load & cache_valid_in;
         load_desc        <= take_load ? desc_in : '0;
         load_sel         <= take_load ? sel_in : '0;
         fault            <= strobe ? fault_in : '0;
         err_code         <= take_fault ? err_in : '0;
      end
   end

endmodule

// File: rtl/segld_top.sv
module segld_top
   import segld_pkg::*;
#(
   parameter int SEL_W = 16,
   parameter int LIM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_target,
   input  logic [SEL_W-1:0] req_sel,
   input  logic [1:0]       req_cpl,
   input  logic             req_long,
   input  logic [LIM_W-1:0] tbl_limit,
   output logic             fetch_req,
   input  logic             desc_valid,
   input  logic             desc_present,
   input  logic             desc_s,
   input  logic [3:0]       desc_type,
   input  logic [1:0]       desc_dpl,
   output logic             res_valid,
   output logic             load_en,
   output logic [SEL_W-1:0] load_sel,
   output logic             load_cache_valid,
   output logic             load_present,
   output logic             load_s,
   output logic [3:0]       load_type,
   output logic [1:0]       load_dpl,
   output logic [FLT_W-1:0] fault,
   output logic [SEL_W-1:0] err_code
);
   seg_state_e       state;
   logic             fetch_q;
   logic [SEL_W-1:0] q_sel;
   logic [1:0]       q_cpl;
   logic             q_ss;
   logic             q_beyond;

   logic d_null, d_ss, d_ud, d_beyond;
   logic prot_fail, absent;
   logic accept, direct, finish;

   logic             strobe, do_load, cache_v;
   logic [SEL_W-1:0] o_sel, o_err;
   logic [FLT_W-1:0] o_flt;
   seg_desc_t        o_desc, desc_live, desc_q;

   segld_sel_decode #(.SEL_W(SEL_W), .LIM_W(LIM_W)) i_decode (
      .target    (req_target),
      .sel       (req_sel),
      .long_mode (req_long),
      .limit     (tbl_limit),
      .is_null   (d_null),
      .is_ss     (d_ss),
      .reject_ud (d_ud),
      .beyond    (d_beyond)
   );

   assign desc_live = {desc_present, desc_s, desc_type, desc_dpl};

   segld_rules i_rules (
      .is_ss     (q_ss),
      .beyond    (q_beyond),
      .rpl       (q_sel[1:0]),
      .cpl       (q_cpl),
      .desc      (desc_live),
      .prot_fail (prot_fail),
      .absent    (absent)
   );

   assign accept = (state == ST_IDLE) & req_valid;
   assign direct = d_ud | d_null;
   assign finish = (state == ST_WAIT) & desc_valid;

   always_comb begin
      strobe  = 1'b0;
      do_load = 1'b0;
      cache_v = 1'b0;
      o_sel   = '0;
      o_err   = '0;
      o_flt   = '0;
      o_desc  = '0;
      if (accept && direct) begin
         strobe = 1'b1;
         if (d_ud) begin
            o_flt[FLT_UD] = 1'b1;
         end else if (d_ss) begin
            o_flt[FLT_GP] = 1'b1;
         end else begin
            do_load = 1'b1;
            o_sel   = req_sel;
         end
      end else if (finish) begin
         strobe = 1'b1;
         o_err  = {q_sel[SEL_W-1:2], 2'b00};
         if (prot_fail) begin
            o_flt[FLT_GP] = 1'b1;
         end else if (absent) begin
            o_flt[q_ss ? FLT_SS : FLT_NP] = 1'b1;
         end else begin
            do_load = 1'b1;
            cache_v = 1'b1;
            o_sel   = q_sel;
            o_desc  = desc_live;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         fetch_q  <= 1'b0;
         q_sel    <= '0;
         q_cpl    <= '0;
         q_ss     <= 1'b0;
         q_beyond <= 1'b0;
      end else begin
         fetch_q <= accept & ~direct;
         case (state)
            ST_IDLE: begin
               if (accept && !direct) begin
                  state    <= ST_WAIT;
                  q_sel    <= req_sel;
                  q_cpl    <= req_cpl;
                  q_ss     <= d_ss;
                  q_beyond <= d_beyond;
               end
            end
            default: begin
               if (desc_valid) begin
                  state <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign fetch_req = fetch_q;

   segld_outreg #(.SEL_W(SEL_W)) i_out (
      .clk              (clk),
      .rst_n            (rst_n),
      .strobe           (strobe),
      .do_load          (do_load),
      .cache_valid_in   (cache_v),
      .desc_in          (o_desc),
      .sel_in           (o_sel),
      .fault_in         (o_flt),
      .err_in           (o_err),
      .res_valid        (res_valid),
      .load_en          (load_en),
      .load_cache_valid (load_cache_valid),
      .load_desc        (desc_q),
      .load_sel         (load_sel),
      .fault            (fault),
      .err_code         (err_code)
   );

   assign load_present = desc_q.present;
   assign load_s       = desc_q.s;
   assign load_type    = desc_q.typ;
   assign load_dpl     = desc_q.dpl;

endmodule

// File: rtl/segld_check.sv
module segld_check
   import segld_pkg::*;
#(
   parameter int SEL_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             desc_valid,
   input logic             fetch_req,
   input logic             res_valid,
   input logic             load_en,
   input logic             load_cache_valid,
   input logic             load_present,
   input logic [SEL_W-1:0] load_sel,
   input logic [FLT_W-1:0] fault,
   input logic [SEL_W-1:0] err_code
);

   a_r11_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($countones({load_en, fault}) == 1));

   a_r9_load_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> (res_valid && fault == '0));

   a_r11_err_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault) |-> (err_code[1:0] == 2'b00));

   a_r1_ud_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fault[FLT_UD] |-> (err_code == '0));

   a_r10_fetch_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !res_valid);

   a_r10_result_cause: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(req_valid || desc_valid));

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid || $past(desc_valid || req_valid));

   a_r3_null_cache: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !load_cache_valid) |-> (load_sel[SEL_W-1:2] == '0));

   a_r9_cache_present: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && load_cache_valid) |-> load_present);

endmodule

bind segld_top segld_check #(.SEL_W(SEL_W)) i_check (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .desc_valid       (desc_valid),
   .fetch_req        (fetch_req),
   .res_valid        (res_valid),
   .load_en          (load_en),
   .load_cache_valid (load_cache_valid),
   .load_present     (load_present),
   .load_sel         (load_sel),
   .fault            (fault),
   .err_code         (err_code)
);

// File: tb/test_segld_top.sv
`timescale 1ns/1ps
module test_segld_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_target = '0;
   logic [15:0] req_sel = '0;
   logic [1:0]  req_cpl = '0;
   logic        req_long = 1'b0;
   logic [15:0] tbl_limit = '0;
   logic        fetch_req;
   logic        desc_valid = 1'b0;
   logic        desc_present = 1'b0;
   logic        desc_s = 1'b0;
   logic [3:0]  desc_type = '0;
   logic [1:0]  desc_dpl = '0;
   logic        res_valid, load_en, load_cache_valid, load_present, load_s;
   logic [15:0] load_sel, err_code;
   logic [3:0]  load_type, fault;
   logic [1:0]  load_dpl;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int n      = 0;

   segld_top i_segld_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
      .req_sel(req_sel), .req_cpl(req_cpl), .req_long(req_long), .tbl_limit(tbl_limit),
      .fetch_req(fetch_req), .desc_valid(desc_valid), .desc_present(desc_present),
      .desc_s(desc_s), .desc_type(desc_type), .desc_dpl(desc_dpl),
      .res_valid(res_valid), .load_en(load_en), .load_sel(load_sel),
      .load_cache_valid(load_cache_valid), .load_present(load_present), .load_s(load_s),
      .load_type(load_type), .load_dpl(load_dpl), .fault(fault), .err_code(err_code)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         fails = fails + 1;
         $display("FAIL watchdog R10: got hung run expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   // Expected outcome from the requirements; fault bits 0 GP, 1 NP, 2 SS, 3 UD (R11)
   function automatic void model(input logic [2:0] tg, input logic lm,
                                 input logic [15:0] sl, input logic [1:0] cp,
                                 input logic [15:0] lim, input logic pr, input logic s,
                                 input logic [3:0] ty, input logic [1:0] dp,
                                 output logic fetch, output logic [45:0] v,
                                 output string tag);
      logic nul, ss, ud, far, dat, cod, bad;
      logic [15:0] ecode;
      nul   = (sl[15:2] == 14'd0);
      ss    = (tg == 3'd2);
      ud    = (tg == 3'd1) || (tg > 3'd5) || (lm && (tg == 3'd0 || tg == 3'd2 || tg == 3'd3));
      ecode = {sl[15:2], 2'b00};
      fetch = 1'b0;
      if (ud) begin
         v   = {1'b0, 1'b0, 8'd0, 16'd0, 4'b1000, 16'd0};
         tag = ((tg == 3'd1) || (tg > 3'd5)) ? "R1" : "R2";
      end else if (nul && ss) begin
         v   = {1'b0, 1'b0, 8'd0, 16'd0, 4'b0001, 16'd0};
         tag = "R4";
      end else if (nul) begin
         v   = {1'b1, 1'b0, 8'd0, sl, 4'b0000, 16'd0};
         tag = "R3";
      end else begin
         fetch = 1'b1;
         far = ({13'd0, sl[15:3]} * 32'd8 + 32'd7) > {16'd0, lim};
         dat = s && !ty[3];
         cod = s && ty[3];
         if (ss)
            bad = far || (sl[1:0] != cp) || (dp != cp) || !(dat && ty[1]);
         else
            bad = far || !(dat || (cod && ty[1]))
                  || ((dat || (cod && !ty[2])) && (sl[1:0] > dp) && (cp > dp));
         if (bad) begin
            v   = {1'b0, 1'b0, 8'd0, 16'd0, 4'b0001, ecode};
            tag = far ? "R7" : (ss ? "R5" : "R6");
         end else if (!pr) begin
            v   = {1'b0, 1'b0, 8'd0, 16'd0, ss ? 4'b0100 : 4'b0010, ecode};
            tag = "R8";
         end else begin
            v   = {1'b1, 1'b1, pr, s, ty, dp, sl, 4'b0000, 16'd0};
            tag = "R9";
         end
      end
   endfunction

   // Called at a negedge; returns at a negedge after the outcome was sampled (R10 timing)
   task automatic one(input logic [2:0] tg, input logic lm, input logic [15:0] sl,
                      input logic [1:0] cp, input logic [15:0] lim, input logic pr,
                      input logic s, input logic [3:0] ty, input logic [1:0] dp,
                      input int delay);
      logic        ef, got_fetch, stray;
      logic [45:0] ev;
      logic [47:0] exp_v, act_v;
      string       tag;
      model(tg, lm, sl, cp, lim, pr, s, ty, dp, ef, ev, tag);
      stray      = 1'b0;
      req_valid  = 1'b1;
      req_target = tg;
      req_long   = lm;
      req_sel    = sl;
      req_cpl    = cp;
      tbl_limit  = lim;
      @(negedge clk);
      req_valid = 1'b0;
      got_fetch = fetch_req;
      if (got_fetch) begin
         if (res_valid) stray = 1'b1;
         for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            if (res_valid || fetch_req) stray = 1'b1;
         end
         desc_valid   = 1'b1;
         desc_present = pr;
         desc_s       = s;
         desc_type    = ty;
         desc_dpl     = dp;
         @(negedge clk);
         desc_valid = 1'b0;
      end
      exp_v = {ef, 1'b0, ev};
      act_v = {got_fetch, stray, load_en, load_cache_valid, load_present, load_s,
               load_type, load_dpl, load_sel, fault, err_code};
      checks = checks + 1;
      if (!res_valid || act_v !== exp_v) begin
         fails = fails + 1;
         if (!res_valid || got_fetch != ef || stray)
            $display("FAIL R10 (%s case): got %h valid %b expected %h valid 1", tag, act_v, res_valid, exp_v);
         else
            $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
      end
      n = n + 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state: no outcome, no fetch, no fault
      checks = checks + 1;
      if ({res_valid, load_en, fetch_req, fault, err_code, load_sel} !== '0) begin
         fails = fails + 1;
         $display("FAIL R10 reset: got %b %b %b %h %h expected all zero",
                  res_valid, load_en, fetch_req, fault, err_code);
      end

      // R1 R2 R3 R4: null selectors over every target code, both modes
      for (int t = 0; t < 8; t++)
         for (int lm = 0; lm < 2; lm++)
            for (int nv = 0; nv < 4; nv++)
               for (int cp = 0; cp < 4; cp++)
                  one(3'(t), 1'(lm), 16'(nv), 2'(cp), 16'hFFFF, 1'b1, 1'b1, 4'h2, 2'(cp), 0);

      // R5 R6 R7 R8 R9: protected-mode sweep with both limit boundary sides
      for (int t = 0; t < 6; t++)
         for (int cp = 0; cp < 4; cp++)
            for (int rp = 0; rp < 4; rp++)
               for (int dp = 0; dp < 4; dp++)
                  for (int k = 0; k < 17; k++)
                     for (int pr = 0; pr < 2; pr++)
                        for (int bz = 0; bz < 2; bz++) begin
                           int idx;
                           idx = 1 + (n % 500);
                           one(3'(t), 1'b0, {13'(idx), 1'(n / 3), 2'(rp)}, 2'(cp),
                               16'(idx * 8 + (bz != 0 ? 6 : 7)), 1'(pr),
                               (k < 16) ? 1'b1 : 1'b0, (k < 16) ? 4'(k) : 4'(n),
                               2'(dp), n % 3);
                        end

      // R2 with the descriptor rules still applied to FS and GS in 64-bit mode
      for (int t = 0; t < 6; t++)
         for (int cp = 0; cp < 4; cp++)
            for (int rp = 0; rp < 4; rp++)
               for (int dp = 0; dp < 4; dp++)
                  for (int k = 0; k < 5; k++)
                     for (int pr = 0; pr < 2; pr++) begin
                        logic [3:0] ty;
                        int idx;
                        case (k)
                           0: ty = 4'h2;
                           1: ty = 4'h0;
                           2: ty = 4'hA;
                           3: ty = 4'h8;
                           default: ty = 4'hE;
                        endcase
                        idx = 2 + (n % 300);
                        one(3'(t), 1'b1, {13'(idx), 1'b0, 2'(rp)}, 2'(cp),
                            16'(idx * 8 + 7 + (n % 2)), 1'(pr), (k != 0), ty,
                            2'(dp), (n + 1) % 3);
                     end

      // R7 upper boundary: last index with a full-size table is in range
      one(3'd4, 1'b0, 16'hFFF8, 2'd0, 16'hFFFF, 1'b1, 1'b1, 4'h2, 2'd0, 1);
      one(3'd2, 1'b0, 16'hFFF8, 2'd0, 16'hFFFE, 1'b1, 1'b1, 4'h2, 2'd0, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule